// File: doc/BRIEF.md
# Bus Abort Status Recorder

This block sits beside the memory controller of a shared bus with three masters: a CPU, a peripheral DMA engine and an Ethernet MAC. Whenever the controller aborts an access, it presents an abort event on the lane of the master concerned. The event carries the faulting address, the access size, the access type and two cause bits: one for an undefined address and one for a misaligned address. The recorder keeps a snapshot of the most recent abort, with a one-hot field naming its master and a full copy of its address. It also keeps one sticky flag per master. The flag says that an abort from that master happened but is no longer the one on show.

Software reads the status word or the address word through a plain register read port. Reading the status word clears the sticky flags. Reading the address word leaves them alone.

Abort events arrive valid-only, one lane per master. The recorder never applies back-pressure: it takes in every event in the cycle it is presented. When several lanes are valid in the same cycle, a fixed priority picks the one that is recorded. The CPU (lane 0) goes first, then DMA (lane 1), then the MAC (lane 2).

Top module: `bus_abort_recorder`

## Requirements
- R1: After reset, the status word and the address word both read as zero.
- R2: A recorded abort loads its full address into the address word (rd_sel=1). It also loads its size, type, undefined-address bit and misaligned bit into the status word.
- R3: Status word layout:
  - bits [1:0] hold the size: 00 byte, 01 half-word, 10 word.
  - bits [3:2] hold the type: 00 data read, 01 data write, 10 code fetch.
  - bit 4 is the undefined-address cause and bit 5 is the misaligned cause.
  - bits [8:6] are the one-hot source: bit 6 CPU, bit 7 DMA, bit 8 MAC.
  - bits [11:9] are the sticky flags in the same master order.
  - all higher bits read as zero.
- R4: With several lanes valid in one cycle, only the lowest-numbered lane is recorded (CPU before DMA before MAC).
- R5: A valid lane that is not recorded sets its own sticky flag.
- R6: When any new abort is recorded, the master named in the source field before it sets its sticky flag, because its record is overwritten. This applies even when the new abort comes from that same master.
- R7: A status read (rd_en=1, rd_sel=0) clears all sticky flags at the next clock edge. A flag that is set by an abort in that same cycle stays set.
- R8: An address read (rd_en=1, rd_sel=1) changes no flag and no field.
- R9: The source field has at most one bit set at all times.
- R10: In cycles with no valid lane, all recorded fields and the address hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abt_valid | input | NM (3) | Per-lane abort event valid (0 CPU, 1 DMA, 2 MAC) |
| abt_addr | input | NM*AW (96) | Per-lane faulting address, lane m in bits [m*AW +: AW] |
| abt_size | input | NM*2 (6) | Per-lane access size code |
| abt_kind | input | NM*2 (6) | Per-lane access type code |
| abt_undef | input | NM (3) | Per-lane undefined-address cause |
| abt_misal | input | NM (3) | Per-lane misaligned-address cause |
| rd_en | input | 1 | Read strobe; with rd_sel=0 it clears the sticky flags |
| rd_sel | input | 1 | 0 selects the status word, 1 selects the address word |
| rd_data | output | DW (32) | Read data for the selected word (combinational) |

## Verification
The assertions run on every cycle. They check that the source field stays one-hot or empty, that a CPU event always takes the record, and that a losing MAC event always leaves its sticky flag. They also check that idle cycles keep the record stable, that a status read with no event clears every flag, and that an address read never drops a flag. Some behaviours can only be shown by the bench's directed scenarios:
- the exact bit placement of each field;
- the captured address value;
- the displaced-record rule for a master that repeats its own abort;
- a status read that collides with an abort in the same cycle.

// File: rtl/abrt_pkg.sv
package abrt_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'b00, SZ_HALF = 2'b01, SZ_WORD = 2'b10} abrt_size_e;
  typedef enum logic [1:0] {KD_DREAD = 2'b00, KD_DWRITE = 2'b01, KD_FETCH = 2'b10} abrt_kind_e;

  typedef struct packed {
    logic       misal;
    logic       undef;
    abrt_kind_e kind;
    abrt_size_e size;
  } abrt_info_t;

  localparam int INFO_W = $bits(abrt_info_t);
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_ADDR   = 1'b1;
endpackage

// File: rtl/abrt_prio_pick.sv
module abrt_prio_pick #(
  parameter int NM = 3
) (
  input  logic [NM-1:0] req,
  output logic [NM-1:0] win
);
  always_comb begin
    win = '0;
    for (int m = NM - 1; m >= 0; m--) begin
      if (req[m]) begin
        win    = '0;
        win[m] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/abrt_record.sv
module abrt_record import abrt_pkg::*; #(
  parameter int NM = 3,
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    win,
  input  logic [NM*AW-1:0] lane_addr,
  input  logic [NM*2-1:0]  lane_size,
  input  logic [NM*2-1:0]  lane_kind,
  input  logic [NM-1:0]    lane_undef,
  input  logic [NM-1:0]    lane_misal,
  output abrt_info_t       info_q,
  output logic [AW-1:0]    addr_q,
  output logic [NM-1:0]    src_q
);
  logic [AW-1:0] sel_addr;
  logic [1:0]    sel_size;
  logic [1:0]    sel_kind;
  logic          sel_undef;
  logic          sel_misal;
  logic          any_win;

  assign any_win = |win;

  always_comb begin
    sel_addr  = '0;
    sel_size  = '0;
    sel_kind  = '0;
    sel_undef = 1'b0;
    sel_misal = 1'b0;
    for (int m = 0; m < NM; m++) begin
      sel_addr  = sel_addr  | (lane_addr[m*AW +: AW] & {AW{win[m]}});
      sel_size  = sel_size  | (lane_size[m*2 +: 2] & {2{win[m]}});
      sel_kind  = sel_kind  | (lane_kind[m*2 +: 2] & {2{win[m]}});
      sel_undef = sel_undef | (lane_undef[m] & win[m]);
      sel_misal = sel_misal | (lane_misal[m] & win[m]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= '0;
      addr_q <= '0;
      src_q  <= '0;
    end else if (any_win) begin
      info_q <= '{misal: sel_misal, undef: sel_undef,
                  kind: abrt_kind_e'(sel_kind), size: abrt_size_e'(sel_size)};
      addr_q <= sel_addr;
      src_q  <= win;
    end
  end
endmodule

// File: rtl/abrt_sticky.sv
module abrt_sticky #(
  parameter int NM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic [NM-1:0] win,
  input  logic [NM-1:0] src_q,
  input  logic          clr,
  output logic [NM-1:0] stk_q
);
  logic any_req;
  assign any_req = |req;

  for (genvar m = 0; m < NM; m++) begin : g_flag
    logic set_m;
    assign set_m = (req[m] & ~win[m]) | (src_q[m] & any_req);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stk_q[m] <= 1'b0;
      else if (set_m) stk_q[m] <= 1'b1;
      else if (clr)   stk_q[m] <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_abort_recorder.sv
module bus_abort_recorder import abrt_pkg::*; #(
  parameter int NM = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    abt_valid,
  input  logic [NM*AW-1:0] abt_addr,
  input  logic [NM*2-1:0]  abt_size,
  input  logic [NM*2-1:0]  abt_kind,
  input  logic [NM-1:0]    abt_undef,
  input  logic [NM-1:0]    abt_misal,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [DW-1:0]    rd_data
);
  localparam int STAT_W = INFO_W + 2 * NM;

  logic [NM-1:0] win;
  abrt_info_t    info_q;
  logic [AW-1:0] addr_q;
  logic [NM-1:0] src_q;
  logic [NM-1:0] stk_q;
  logic          stat_clr;
  logic [DW-1:0] status_w;
  logic [DW-1:0] address_w;

  abrt_prio_pick #(.NM(NM)) u_pick (
    .req (abt_valid),
    .win (win)
  );

  abrt_record #(.NM(NM), .AW(AW)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .win        (win),
    .lane_addr  (abt_addr),
    .lane_size  (abt_size),
    .lane_kind  (abt_kind),
    .lane_undef (abt_undef),
    .lane_misal (abt_misal),
    .info_q     (info_q),
    .addr_q     (addr_q),
    .src_q      (src_q)
  );

  assign stat_clr = rd_en & (rd_sel == SEL_STATUS);

  abrt_sticky #(.NM(NM)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (abt_valid),
    .win   (win),
    .src_q (src_q),
    .clr   (stat_clr),
    .stk_q (stk_q)
  );

  always_comb begin
    status_w = '0;
    status_w[STAT_W-1:0] = {stk_q, src_q, info_q};
    address_w = '0;
    address_w[AW-1:0] = addr_q;
  end

  assign rd_data = (rd_sel == SEL_ADDR) ? address_w : status_w;
endmodule

// File: rtl/bus_abort_recorder_chk.sv
module bus_abort_recorder_chk #(
  parameter int NM = 3,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] abt_valid,
  input logic          rd_en,
  input logic          rd_sel,
  input logic [NM-1:0] src_q,
  input logic [NM-1:0] stk_q,
  input logic [AW-1:0] addr_q
);
  a_r9_src_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_q));

  a_r4_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    abt_valid[0] |=> src_q[0]);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|abt_valid) |=> ($stable(src_q) && $stable(addr_q)));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel && !(|abt_valid)) |=> (stk_q == '0));

  a_r5_loser_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_valid[0] && abt_valid[NM-1]) |=> stk_q[NM-1]);

  a_r8_addr_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel) |=> ((stk_q & $past(stk_q)) == $past(stk_q)));
endmodule

bind bus_abort_recorder bus_abort_recorder_chk #(.NM(NM), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .abt_valid (abt_valid),
  .rd_en     (rd_en),
  .rd_sel    (rd_sel),
  .src_q     (src_q),
  .stk_q     (stk_q),
  .addr_q    (addr_q)
);

// File: tb/bus_abort_recorder_bench.sv
module bus_abort_recorder_bench;
  localparam int NM = 3;
  localparam int AW = 32;
  localparam int DW = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NM-1:0]    abt_valid = '0;
  logic [NM*AW-1:0] abt_addr = '0;
  logic [NM*2-1:0]  abt_size = '0;
  logic [NM*2-1:0]  abt_kind = '0;
  logic [NM-1:0]    abt_undef = '0;
  logic [NM-1:0]    abt_misal = '0;
  logic             rd_en = 1'b0;
  logic             rd_sel = 1'b0;
  logic [DW-1:0]    rd_data;

  int  nchecks = 0;
  int  nerrs = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  bus_abort_recorder #(.NM(NM), .AW(AW), .DW(DW)) u_bus_abort_recorder (
    .clk(clk), .rst_n(rst_n), .abt_valid(abt_valid), .abt_addr(abt_addr),
    .abt_size(abt_size), .abt_kind(abt_kind), .abt_undef(abt_undef),
    .abt_misal(abt_misal), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [31:0] st(input logic [1:0] sz, input logic [1:0] kd,
                                     input logic und, input logic mis,
                                     input logic [2:0] src, input logic [2:0] stk);
    return {20'b0, stk, src, mis, und, kd, sz};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lane(input int m, input logic [31:0] a, input logic [1:0] sz,
                      input logic [1:0] kd, input logic und, input logic mis);
    abt_valid[m]       = 1'b1;
    abt_addr[m*AW +: AW] = a;
    abt_size[m*2 +: 2] = sz;
    abt_kind[m*2 +: 2] = kd;
    abt_undef[m]       = und;
    abt_misal[m]       = mis;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    abt_valid = '0;
    rd_en     = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, v); chk("R1 status", v, 32'h0);
    rd(1'b1, v); chk("R1 address", v, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    lane(1, 32'h2000_0002, 2'b10, 2'b00, 1'b0, 1'b1);
    step();
    rd(1'b0, v); chk("R2 R3 dma status", v, st(2'b10, 2'b00, 1'b0, 1'b1, 3'b010, 3'b000));
    rd(1'b1, v); chk("R2 dma address", v, 32'h2000_0002);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    lane(0, 32'h0FFF_F000, 2'b01, 2'b01, 1'b1, 1'b0);
    lane(2, 32'h1234_5677, 2'b00, 2'b10, 1'b0, 1'b0);
    step();
    rd(1'b0, v); chk("R4 R5 R6 prio status", v, st(2'b01, 2'b01, 1'b1, 1'b0, 3'b001, 3'b110));
    rd(1'b1, v); chk("R4 prio address", v, 32'h0FFF_F000);
  endtask

  task automatic t_reads();
    logic [31:0] v;
    rd_en = 1'b1;
    rd(1'b1, v); chk("R8 address during read", v, 32'h0FFF_F000);
    step();
    rd(1'b0, v); chk("R8 flags after address read", v, st(2'b01, 2'b01, 1'b1, 1'b0, 3'b001, 3'b110));
    rd_en = 1'b1;
    rd(1'b0, v); chk("R7 status shown during read", v, st(2'b01, 2'b01, 1'b1, 1'b0, 3'b001, 3'b110));
    step();
    rd(1'b0, v); chk("R7 flags cleared", v, st(2'b01, 2'b01, 1'b1, 1'b0, 3'b001, 3'b000));
  endtask

  task automatic t_repeat();
    logic [31:0] v;
    lane(0, 32'h0000_0104, 2'b10, 2'b10, 1'b0, 1'b0);
    step();
    rd(1'b0, v); chk("R6 repeat same master", v, st(2'b10, 2'b10, 1'b0, 1'b0, 3'b001, 3'b001));
  endtask

  task automatic t_read_race();
    logic [31:0] v;
    rd_sel = 1'b0;
    rd_en  = 1'b1;
    lane(2, 32'hFFFF_FFFE, 2'b01, 2'b00, 1'b0, 1'b0);
    step();
    rd(1'b0, v); chk("R7 set wins over clear", v, st(2'b01, 2'b00, 1'b0, 1'b0, 3'b100, 3'b001));
    rd(1'b1, v); chk("R2 mac address", v, 32'hFFFF_FFFE);
  endtask

  task automatic t_idle();
    logic [31:0] s0, a0, v;
    rd(1'b0, s0);
    rd(1'b1, a0);
    abt_addr = {NM{32'hDEAD_BEEF}};
    abt_size = '1;
    for (int i = 0; i < 5; i++) step();
    rd(1'b0, v); chk("R10 idle status", v, s0);
    rd(1'b1, v); chk("R10 idle address", v, a0);
  endtask

  task automatic t_all();
    logic [31:0] v;
    lane(0, 32'hA5A5_0000, 2'b00, 2'b01, 1'b0, 1'b0);
    lane(1, 32'h5A5A_0001, 2'b10, 2'b00, 1'b1, 1'b1);
    lane(2, 32'h0101_0102, 2'b01, 2'b10, 1'b1, 1'b0);
    step();
    rd(1'b0, v); chk("R4 R5 all lanes status", v, st(2'b00, 2'b01, 1'b0, 1'b0, 3'b001, 3'b111));
    rd(1'b1, v); chk("R4 all lanes address", v, 32'hA5A5_0000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nchecks++;
    nerrs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_prio();
    t_reads();
    t_repeat();
    t_read_race();
    t_idle();
    t_all();
    finish_run();
  end
endmodule